// File: doc/BRIEF.md
# Encoded Ratio Audio Clock Divider

This block derives two audio clocks from a single audio module clock: a master clock for an external converter and a bit clock for the local serial audio port. Each output has its own 4-bit ratio code. Both codes are decoded through one shared table of fixed ratios. The table includes ratios that are not powers of two, such as 6, 12, 24, 48, 96 and 176.

Software picks the code whose ratio equals the module clock divided by the product of the sample rate and the number of clocks per frame. Only ratios in the table can be produced. The module clock is normally 22.5792 MHz for the 44.1 kHz family of rates and 24.576 MHz for the other rates. Choosing that rate is done outside this block.

The bit clock side also gives two one-cycle pulses in the module clock domain, one for each edge of the bit clock. A serializer uses the falling-edge pulse to launch data and the rising-edge pulse to capture data. A new code, or a change of the master clock enable, is taken only at a period boundary, so a ratio change never produces a runt pulse.

Top module: `audclk_divider`

## Requirements
- R1: Codes 1 to 15 select these ratios in order: 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 176, 192. One output period lasts that many module clock cycles.
- R2: For every even ratio N, the output is high for N/2 module cycles and then low for N/2 cycles. Each period starts with the high half.
- R3: Ratio 1 (code 1) passes the module clock through to the output unchanged. The output is high while the clock is high and low while it is low.
- R4: Code 0 is reserved. Selecting it holds the output low, and on the bit clock side both edge pulses stay low.
- R5: While `mclk_oe` is 0, `mclk_out` is held low. `mclk_oe` is sampled only at a period boundary, in the same way as a code.
- R6: A code written in the middle of a period has no effect until the current period ends. The new ratio starts with a rising edge. A stopped output (code 0 or enable off) starts on the first clock edge after it is given a nonzero code.
- R7: `bclk_capture` is high for the one module cycle that starts with each rising edge of `bclk_out`. `bclk_launch` is high for the cycle that starts with each falling edge. At ratio 1, both pulses are high on every cycle.
- R8: While `rst` is high (synchronous, active high), both clock outputs and both edge pulses are low.
- R9: The two outputs run independently of each other and decode their codes through the same table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio module clock |
| rst | input | 1 | Synchronous reset, active high |
| mclk_code | input | 4 | Ratio code for the master clock |
| bclk_code | input | 4 | Ratio code for the bit clock |
| mclk_oe | input | 1 | Master clock output enable |
| mclk_out | output | 1 | Divided master clock |
| bclk_out | output | 1 | Divided bit clock |
| bclk_launch | output | 1 | One-cycle pulse at each bit clock falling edge |
| bclk_capture | output | 1 | One-cycle pulse at each bit clock rising edge |

## Verification
The bit clock code is stepped through all fifteen ratios, each held for several periods. This shows whether each code maps to the right period length and duty. It also shows whether the odd-looking entries (6, 176, 192) come out of the table in the right place.

Codes are also rewritten in the middle of a period, moving both up and down in ratio and into and out of code 0 and ratio 1. These runs tell a boundary-aligned change apart from an immediate one that would produce a runt pulse.

The master clock enable is toggled while its code stays fixed. This separates gating at the period boundary from a stuck or ungated output, and shows that the two channels do not affect each other.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    localparam int CODE_W = 4;
    localparam int CNT_W  = 8;   // wide enough for the largest ratio (192)
    localparam int N_CHAN = 2;   // channel 0: master clock, channel 1: bit clock

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  ratio_t;

    typedef struct packed {
        ratio_t ratio;   // active ratio, 0 = stopped
        ratio_t cnt;     // position inside the current period
        logic   lvl;     // registered output level
        logic   rise;    // period started on this cycle
        logic   fall;    // low half started on this cycle
    } div_state_t;

    // Shared ratio table; code 0 is reserved and means stopped
    function automatic ratio_t code_to_ratio(input code_t c);
        ratio_t r;
        case (c)
            code_t'(1):  r = ratio_t'(1);
            code_t'(2):  r = ratio_t'(2);
            code_t'(3):  r = ratio_t'(4);
            code_t'(4):  r = ratio_t'(6);
            code_t'(5):  r = ratio_t'(8);
            code_t'(6):  r = ratio_t'(12);
            code_t'(7):  r = ratio_t'(16);
            code_t'(8):  r = ratio_t'(24);
            code_t'(9):  r = ratio_t'(32);
            code_t'(10): r = ratio_t'(48);
            code_t'(11): r = ratio_t'(64);
            code_t'(12): r = ratio_t'(96);
            code_t'(13): r = ratio_t'(128);
            code_t'(14): r = ratio_t'(176);
            code_t'(15): r = ratio_t'(192);
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/audclk_code_dec.sv
module audclk_code_dec
    import audclk_pkg::*;
(
    input  code_t  code,
    input  logic   en,
    output ratio_t ratio
);
    // A disabled channel decodes as stopped, so gating follows the boundary rule
    assign ratio = en ? code_to_ratio(code) : '0;
endmodule

// File: rtl/audclk_div_chan.sv
module audclk_div_chan
    import audclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ratio_t     req_ratio,
    output div_state_t st
);
    div_state_t nxt;
    logic       wrap;
    ratio_t     half;

    always_comb begin
        // A stopped channel sits at a boundary on every cycle
        wrap = (st.ratio == '0) || (st.cnt == ratio_t'(st.ratio - ratio_t'(1)));
        nxt  = st;
        if (wrap) begin
            nxt.ratio = req_ratio;
            nxt.cnt   = '0;
        end else begin
            nxt.cnt   = ratio_t'(st.cnt + ratio_t'(1));
        end
        half = nxt.ratio >> 1;
        if (nxt.ratio == ratio_t'(1)) begin
            nxt.lvl  = 1'b1;
            nxt.rise = 1'b1;
            nxt.fall = 1'b1;
        end else if (nxt.ratio == '0) begin
            nxt.lvl  = 1'b0;
            nxt.rise = 1'b0;
            nxt.fall = 1'b0;
        end else begin
            nxt.lvl  = (nxt.cnt < half);
            nxt.rise = wrap;
            nxt.fall = (nxt.cnt == half);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end
endmodule

// File: rtl/audclk_divider.sv
module audclk_divider
    import audclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mclk_code,
    input  logic [3:0] bclk_code,
    input  logic       mclk_oe,
    output logic       mclk_out,
    output logic       bclk_out,
    output logic       bclk_launch,
    output logic       bclk_capture
);
    code_t      code_a [N_CHAN];
    logic       en_a   [N_CHAN];
    div_state_t st_a   [N_CHAN];
    logic       out_a  [N_CHAN];
    logic       mclk_lvl;
    logic       bclk_lvl;

    assign code_a[0] = mclk_code;
    assign en_a[0]   = mclk_oe;
    assign code_a[1] = bclk_code;
    assign en_a[1]   = 1'b1;

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        ratio_t req;
        audclk_code_dec u_dec (
            .code  (code_a[i]),
            .en    (en_a[i]),
            .ratio (req)
        );
        audclk_div_chan u_div (
            .clk       (clk),
            .rst       (rst),
            .req_ratio (req),
            .st        (st_a[i])
        );
        // Ratio 1 forwards the module clock itself
        assign out_a[i] = (st_a[i].ratio == ratio_t'(1)) ? clk : st_a[i].lvl;
    end

    assign mclk_lvl     = st_a[0].lvl;
    assign bclk_lvl     = st_a[1].lvl;
    assign mclk_out     = out_a[0];
    assign bclk_out     = out_a[1];
    assign bclk_launch  = st_a[1].fall;
    assign bclk_capture = st_a[1].rise;
endmodule

// File: rtl/audclk_divider_chk.sv
module audclk_divider_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] mclk_code,
    input logic [3:0] bclk_code,
    input logic       mclk_oe,
    input logic       mclk_lvl,
    input logic       bclk_lvl,
    input logic       bclk_launch,
    input logic       bclk_capture
);
    // R7
    bclk_rise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bclk_lvl) |-> bclk_capture);

    // R7
    bclk_fall_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bclk_lvl) |-> bclk_launch);

    // R4
    bclk_stop_code_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bclk_lvl) |-> ($past(bclk_code) != 4'd0));

    // R5
    mclk_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mclk_lvl) |-> $past(mclk_oe));

    // R4
    mclk_stop_code_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mclk_lvl) |-> ($past(mclk_code) != 4'd0));

    // R7
    bclk_capture_high_chk: assert property (@(posedge clk) disable iff (rst)
        bclk_capture |-> bclk_lvl);
endmodule

bind audclk_divider audclk_divider_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mclk_code    (mclk_code),
    .bclk_code    (bclk_code),
    .mclk_oe      (mclk_oe),
    .mclk_lvl     (mclk_lvl),
    .bclk_lvl     (bclk_lvl),
    .bclk_launch  (bclk_launch),
    .bclk_capture (bclk_capture)
);

// File: tb/sim_audclk_divider.sv
`timescale 1ns/100ps
module sim_audclk_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mclk_code = 4'd0;
    logic [3:0] bclk_code = 4'd0;
    logic       mclk_oe = 1'b0;
    logic       mclk_out, bclk_out, bclk_launch, bclk_capture;

    always #2.5 clk = ~clk;

    audclk_divider u0 (
        .clk(clk), .rst(rst), .mclk_code(mclk_code), .bclk_code(bclk_code),
        .mclk_oe(mclk_oe), .mclk_out(mclk_out), .bclk_out(bclk_out),
        .bclk_launch(bclk_launch), .bclk_capture(bclk_capture)
    );

    int checks = 0;
    int errors = 0;
    int tbl [16] = '{0, 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 176, 192};

    // Expected waveform, one entry per module cycle
    bit b_lvl[$], b_rise[$], b_fall[$];
    bit m_lvl[$], m_rise[$], m_fall[$];
    int b_cur = 0;
    int m_cur = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    function automatic void refill(ref bit lv[$], ref bit rs[$], ref bit fl[$], input int r);
        if (r == 0) begin
            lv.push_back(0); rs.push_back(0); fl.push_back(0);
        end else if (r == 1) begin
            lv.push_back(1); rs.push_back(1); fl.push_back(1);
        end else begin
            for (int k = 0; k < r; k++) begin
                lv.push_back(k < r/2);
                rs.push_back(k == 0);
                fl.push_back(k == r/2);
            end
        end
    endfunction

    function automatic string btag(input int r);
        if (r == 0)      return "R4";
        else if (r == 1) return "R3";
        else             return "R1 R2 R6";
    endfunction

    // Reference model: step and compare once per clock, away from the edges
    always @(posedge clk) begin
        #1;
        if (running) begin
            bit eb, er, ef, em, dm1, dm2;
            if (b_lvl.size() == 0) begin
                b_cur = tbl[bclk_code];
                refill(b_lvl, b_rise, b_fall, b_cur);
            end
            if (m_lvl.size() == 0) begin
                m_cur = mclk_oe ? tbl[mclk_code] : 0;
                refill(m_lvl, m_rise, m_fall, m_cur);
            end
            eb = b_lvl.pop_front(); er = b_rise.pop_front(); ef = b_fall.pop_front();
            em = m_lvl.pop_front(); dm1 = m_rise.pop_front(); dm2 = m_fall.pop_front();
            check(bclk_out == eb, {"bclk level ", btag(b_cur)}, bclk_out, eb);
            // R7
            check(bclk_capture == er, "R7 capture", bclk_capture, er);
            check(bclk_launch == ef, "R7 launch", bclk_launch, ef);
            // R5 R9
            check(mclk_out == em, (m_cur == 0) ? "R5 mclk held" : "R9 mclk level", mclk_out, em);
            if (b_cur == 1 || m_cur == 1) begin
                #2.5;
                // R3: low phase of the clock must appear at the output
                if (b_cur == 1) check(bclk_out == 1'b0, "R3 bclk low phase", bclk_out, 0);
                if (m_cur == 1) check(mclk_out == 1'b0, "R3 mclk low phase", mclk_out, 0);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        mclk_code = 4'd5;
        mclk_oe   = 1'b1;
        bclk_code = 4'd3;
        wait_cyc(4);
        // R8
        check(mclk_out == 0 && bclk_out == 0, "R8 reset clocks", {mclk_out, bclk_out}, 0);
        check(bclk_launch == 0 && bclk_capture == 0, "R8 reset pulses",
              {bclk_launch, bclk_capture}, 0);
        rst = 1'b0;
        running = 1'b1;
        wait_cyc(40);
        // R1: every code, several periods each
        for (int c = 1; c < 16; c++) begin
            bclk_code = 4'(c);
            wait_cyc(3 * tbl[c] + 7);
        end
        // R4: stop, then restart
        bclk_code = 4'd0;
        wait_cyc(400);
        bclk_code = 4'd4;
        wait_cyc(30);
        // R6: mid-period changes, up and down
        bclk_code = 4'd15;
        wait_cyc(50);
        bclk_code = 4'd2;
        wait_cyc(7);
        bclk_code = 4'd1;
        wait_cyc(9);
        bclk_code = 4'd14;
        wait_cyc(100);
        bclk_code = 4'd0;
        wait_cyc(300);
        // R5: toggle enable mid-period
        mclk_code = 4'd8;
        wait_cyc(37);
        mclk_oe = 1'b0;
        wait_cyc(60);
        mclk_oe = 1'b1;
        wait_cyc(11);
        mclk_code = 4'd1;
        wait_cyc(60);
        mclk_oe = 1'b0;
        wait_cyc(10);
        mclk_code = 4'd0;
        mclk_oe = 1'b1;
        wait_cyc(20);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule